// File: doc/BRIEF.md
# Sequential Stream Buffer Prefetcher

This block sits next to a data cache and keeps a handful of independent stream buffers. Each buffer is a small ring of slots that holds the next few consecutive cache lines of one access stream. The lines are fetched ahead of demand into the buffers rather than into the cache, so deep lookahead cannot evict useful cache contents. When the cache misses, it hands the missing line address to the block. Only the oldest slot (the head) of every buffer is compared with that address, and all heads are compared at once. On a head match the line is returned from the buffer and the freed slot is reloaded with the line `DEPTH` beyond the one consumed. If no head matches, the least recently used buffer is cleared and restarted on the lines that follow the miss.

All data paths use valid/ready handshakes. A miss is taken only while the block is idle, and one miss is handled at a time. A response stays valid, with its fields stable, until `resp_ready` is high. A prefetch request stays valid, with its line and tag stable, until `pf_ready` is high. Prefetch requests are plain line reads. Each request carries an opaque tag, and the memory side must return that tag unchanged with the data. Fill returns cannot be stalled and are taken in the cycle they arrive.

Line addresses are counted in cache lines. The page number of a line is the line address shifted right by `PG_LOG2`. The default of 6 gives 64 lines of 64 bytes, which is a 4 KiB page.

Top module: `strm_pf`

## Requirements
- R1: After reset the block is idle: `miss_ready` is 1, `resp_valid` is 0 and `pf_valid` is 0.
- R2: A miss that matches no valid head is answered one cycle after acceptance with `resp_hit`=0. The least recently used buffer is restarted on lines miss+1 through miss+`DEPTH`, and each of those lines is requested on the prefetch port.
- R3: A miss that matches a head whose data has arrived is answered one cycle after acceptance with `resp_hit`=1 and `resp_data` equal to that line's fill data. The line `DEPTH` beyond it is then requested.
- R4: A miss that matches a head whose fill is still outstanding gets no response until that fill arrives. It is then answered with `resp_hit`=1 and the fill data.
- R5: Only heads are compared. A line held in a buffer slot behind the head counts as a miss and starts a new stream.
- R6: Every head hit and every restart make that buffer the most recently used. A restart always replaces the buffer that has gone longest without a hit or restart.
- R7: No prefetch is requested for a line whose page number differs from the line it was derived from (the miss line for seeds, the consumed head for refills). Such a slot stays empty and never matches.
- R8: A fill whose tag belongs to a buffer restarted after the request was issued is discarded and never supplies data.
- R9: While `pf_valid` is 1 and `pf_ready` is 0, `pf_valid`, `pf_line` and `pf_tag` hold their values.
- R10: While `resp_valid` is 1, `miss_ready` is 0. A response held by `resp_ready`=0 keeps `resp_hit` and `resp_data` stable. After the handshake `resp_valid` drops and the block is idle again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Cache miss offered |
| miss_ready | output | 1 | Block can accept a miss |
| miss_line | input | LINE_AW | Line address of the miss |
| resp_valid | output | 1 | Response to the accepted miss |
| resp_ready | input | 1 | Cache takes the response |
| resp_hit | output | 1 | 1 if the line came from a buffer |
| resp_data | output | DATA_W | Line data on a hit, zero otherwise |
| pf_valid | output | 1 | Prefetch read request pending |
| pf_ready | input | 1 | Memory takes the request |
| pf_line | output | LINE_AW | Line address to read |
| pf_tag | output | TAG_W | Opaque tag to return with the fill |
| fill_valid | input | 1 | Fill data arriving |
| fill_tag | input | TAG_W | Tag of the request being filled |
| fill_data | input | DATA_W | Line data of the fill |

## Verification
The bench builds the block with four buffers two slots deep, 20-bit line addresses, 32-bit data, three generation bits and `PG_LOG2`=4. Pages of 16 lines let a short run hit the page edge, where both the seed and the refill are suppressed. With four buffers a few distinct streams are enough to force a chain of LRU evictions. Depth two keeps a head match on a still-pending slot, and a matching line that sits behind a head, reachable within a few misses. A memory model with a switch that holds fills back lets the bench restart a buffer while old fills are still outstanding.

// File: rtl/strm_pf_pkg.sv
package strm_pf_pkg;
  typedef enum logic [1:0] {
    ENT_EMPTY = 2'd0,
    ENT_WANT  = 2'd1,
    ENT_PEND  = 2'd2,
    ENT_FULL  = 2'd3
  } ent_st_e;

  typedef enum logic [1:0] {
    CTL_IDLE = 2'd0,
    CTL_WAIT = 2'd1,
    CTL_RESP = 2'd2
  } ctl_st_e;
endpackage

// File: rtl/strm_pf_lru.sv
module strm_pf_lru #(
  parameter int NBUF  = 4,
  parameter int BUF_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_i,
  input  logic [BUF_W-1:0] touch_idx_i,
  output logic [BUF_W-1:0] victim_o
);
  // age 0 = most recent, NBUF-1 = oldest; ages always form a permutation
  logic [BUF_W-1:0] age_q [NBUF];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBUF; i++) age_q[i] <= BUF_W'(i);
    end else if (touch_i) begin
      for (int i = 0; i < NBUF; i++) begin
        if (BUF_W'(i) == touch_idx_i)
          age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx_i])
          age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_o = '0;
    for (int i = 0; i < NBUF; i++)
      if (age_q[i] == BUF_W'(NBUF - 1)) victim_o = BUF_W'(i);
  end
endmodule

// File: rtl/strm_pf_arb.sv
module strm_pf_arb #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req_i,
  output logic             gnt_v_o,
  output logic [IDX_W-1:0] gnt_idx_o
);
  // fixed priority, lowest flat index wins
  always_comb begin
    gnt_v_o   = 1'b0;
    gnt_idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_v_o   = 1'b1;
        gnt_idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/strm_pf_buf.sv
module strm_pf_buf
  import strm_pf_pkg::*;
#(
  parameter int LINE_AW = 26,
  parameter int DATA_W  = 64,
  parameter int DEPTH   = 2,
  parameter int GEN_W   = 3,
  parameter int PG_LOG2 = 6,
  parameter int SLOT_W  = 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            alloc_i,
  input  logic [LINE_AW-1:0]              alloc_line_i,
  input  logic                            pop_i,
  input  logic                            fill_v_i,
  input  logic [GEN_W-1:0]                fill_gen_i,
  input  logic [SLOT_W-1:0]               fill_slot_i,
  input  logic [DATA_W-1:0]               fill_data_i,
  input  logic                            issue_i,
  input  logic [SLOT_W-1:0]               issue_slot_i,
  output logic [LINE_AW-1:0]              head_line_o,
  output ent_st_e                         head_st_o,
  output logic [DATA_W-1:0]               head_data_o,
  output logic [DEPTH-1:0]                want_o,
  output logic [DEPTH-1:0][LINE_AW-1:0]   slot_line_o,
  output logic [GEN_W-1:0]                gen_o
);
  ent_st_e             st_q   [DEPTH];
  logic [LINE_AW-1:0]  line_q [DEPTH];
  logic [DATA_W-1:0]   data_q [DEPTH];
  logic [SLOT_W-1:0]   hptr_q;
  logic [GEN_W-1:0]    gen_q;

  logic                fill_ok;
  logic [LINE_AW-1:0]  refill_line;
  logic                refill_ok;
  logic [SLOT_W-1:0]   hptr_nx;

  always_comb begin
    fill_ok     = fill_v_i && (fill_gen_i == gen_q) && (st_q[fill_slot_i] == ENT_PEND);
    refill_line = line_q[hptr_q] + LINE_AW'(DEPTH);
    refill_ok   = (refill_line >> PG_LOG2) == (line_q[hptr_q] >> PG_LOG2);
    hptr_nx     = (hptr_q == SLOT_W'(DEPTH - 1)) ? '0 : hptr_q + 1'b1;
  end

  // slot state: later statements take priority (restart over everything)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) st_q[j] <= ENT_EMPTY;
      hptr_q <= '0;
      gen_q  <= '0;
    end else begin
      if (fill_ok) st_q[fill_slot_i] <= ENT_FULL;
      if (issue_i) st_q[issue_slot_i] <= ENT_PEND;
      if (pop_i) begin
        st_q[hptr_q] <= refill_ok ? ENT_WANT : ENT_EMPTY;
        hptr_q       <= hptr_nx;
      end
      if (alloc_i) begin
        for (int j = 0; j < DEPTH; j++) begin
          if (((alloc_line_i + LINE_AW'(j + 1)) >> PG_LOG2) == (alloc_line_i >> PG_LOG2))
            st_q[j] <= ENT_WANT;
          else
            st_q[j] <= ENT_EMPTY;
        end
        hptr_q <= '0;
        gen_q  <= gen_q + 1'b1;
      end
    end
  end

  // payload, no reset needed: guarded by slot state
  always_ff @(posedge clk) begin
    if (fill_ok) data_q[fill_slot_i] <= fill_data_i;
    if (pop_i) line_q[hptr_q] <= refill_line;
    if (alloc_i)
      for (int j = 0; j < DEPTH; j++) line_q[j] <= alloc_line_i + LINE_AW'(j + 1);
  end

  always_comb begin
    head_line_o = line_q[hptr_q];
    head_st_o   = st_q[hptr_q];
    head_data_o = data_q[hptr_q];
    gen_o       = gen_q;
    for (int j = 0; j < DEPTH; j++) begin
      want_o[j]      = (st_q[j] == ENT_WANT);
      slot_line_o[j] = line_q[j];
    end
  end
endmodule

// File: rtl/strm_pf.sv
module strm_pf
  import strm_pf_pkg::*;
#(
  parameter int LINE_AW = 26,
  parameter int DATA_W  = 64,
  parameter int NBUF    = 4,
  parameter int DEPTH   = 2,
  parameter int GEN_W   = 3,
  parameter int PG_LOG2 = 6,
  localparam int BUF_W  = (NBUF  > 1) ? $clog2(NBUF)  : 1,
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int TAG_W  = GEN_W + BUF_W + SLOT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               miss_valid,
  output logic               miss_ready,
  input  logic [LINE_AW-1:0] miss_line,
  output logic               resp_valid,
  input  logic               resp_ready,
  output logic               resp_hit,
  output logic [DATA_W-1:0]  resp_data,
  output logic               pf_valid,
  input  logic               pf_ready,
  output logic [LINE_AW-1:0] pf_line,
  output logic [TAG_W-1:0]   pf_tag,
  input  logic               fill_valid,
  input  logic [TAG_W-1:0]   fill_tag,
  input  logic [DATA_W-1:0]  fill_data
);
  localparam int NSLOT = NBUF * DEPTH;
  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  // per-buffer views
  logic [LINE_AW-1:0]            head_line [NBUF];
  ent_st_e                       head_st   [NBUF];
  logic [DATA_W-1:0]             head_data [NBUF];
  logic [DEPTH-1:0][LINE_AW-1:0] slot_line [NBUF];
  logic [GEN_W-1:0]              gen       [NBUF];
  logic [NSLOT-1:0]              want;

  // control
  ctl_st_e           ctl_q;
  logic [BUF_W-1:0]  wait_buf_q;
  logic              resp_hit_q;
  logic [DATA_W-1:0] resp_data_q;

  logic              any_match;
  logic [BUF_W-1:0]  hit_idx;
  logic [BUF_W-1:0]  victim;
  logic              accept, wait_done, pop_v, alloc_v;
  logic [BUF_W-1:0]  pop_buf, touch_idx;

  // fill decode: tag = {gen, buffer, slot}
  logic [GEN_W-1:0]  fill_gen;
  logic [BUF_W-1:0]  fill_buf;
  logic [SLOT_W-1:0] fill_slot;

  // prefetch issue
  logic              gnt_v;
  logic [IDX_W-1:0]  gnt_idx;
  logic [BUF_W-1:0]  gnt_buf;
  logic [SLOT_W-1:0] gnt_slot;
  logic              pf_load;
  logic              pf_valid_q;
  logic [LINE_AW-1:0] pf_line_q;
  logic [TAG_W-1:0]  pf_tag_q;

  assign fill_gen  = fill_tag[TAG_W-1 -: GEN_W];
  assign fill_buf  = fill_tag[SLOT_W +: BUF_W];
  assign fill_slot = fill_tag[SLOT_W-1:0];

  // all heads compared in parallel; lowest index wins on duplicates
  always_comb begin
    any_match = 1'b0;
    hit_idx   = '0;
    for (int b = NBUF - 1; b >= 0; b--) begin
      if (head_st[b] != ENT_EMPTY && head_line[b] == miss_line) begin
        any_match = 1'b1;
        hit_idx   = BUF_W'(b);
      end
    end
  end

  always_comb begin
    accept    = (ctl_q == CTL_IDLE) && miss_valid;
    wait_done = (ctl_q == CTL_WAIT) && (head_st[wait_buf_q] == ENT_FULL);
    pop_v     = (accept && any_match && head_st[hit_idx] == ENT_FULL) || wait_done;
    pop_buf   = (ctl_q == CTL_WAIT) ? wait_buf_q : hit_idx;
    alloc_v   = accept && !any_match;
    touch_idx = any_match ? hit_idx : victim;
    pf_load   = !pf_valid_q || pf_ready;
    gnt_buf   = BUF_W'(int'(gnt_idx) / DEPTH);
    gnt_slot  = SLOT_W'(int'(gnt_idx) % DEPTH);
  end

  strm_pf_lru #(.NBUF(NBUF), .BUF_W(BUF_W)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_i    (accept),
    .touch_idx_i(touch_idx),
    .victim_o   (victim)
  );

  strm_pf_arb #(.N(NSLOT), .IDX_W(IDX_W)) u_arb (
    .req_i    (want),
    .gnt_v_o  (gnt_v),
    .gnt_idx_o(gnt_idx)
  );

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    strm_pf_buf #(
      .LINE_AW(LINE_AW), .DATA_W(DATA_W), .DEPTH(DEPTH),
      .GEN_W(GEN_W), .PG_LOG2(PG_LOG2), .SLOT_W(SLOT_W)
    ) u_buf (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_i     (alloc_v && victim == BUF_W'(b)),
      .alloc_line_i(miss_line),
      .pop_i       (pop_v && pop_buf == BUF_W'(b)),
      .fill_v_i    (fill_valid && fill_buf == BUF_W'(b)),
      .fill_gen_i  (fill_gen),
      .fill_slot_i (fill_slot),
      .fill_data_i (fill_data),
      .issue_i     (pf_load && gnt_v && gnt_buf == BUF_W'(b)),
      .issue_slot_i(gnt_slot),
      .head_line_o (head_line[b]),
      .head_st_o   (head_st[b]),
      .head_data_o (head_data[b]),
      .want_o      (want[b*DEPTH +: DEPTH]),
      .slot_line_o (slot_line[b]),
      .gen_o       (gen[b])
    );
  end

  // miss handling, one in flight
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q      <= CTL_IDLE;
      wait_buf_q <= '0;
      resp_hit_q <= 1'b0;
    end else begin
      case (ctl_q)
        CTL_IDLE: if (accept) begin
          if (!any_match) begin
            ctl_q      <= CTL_RESP;
            resp_hit_q <= 1'b0;
          end else if (head_st[hit_idx] == ENT_FULL) begin
            ctl_q      <= CTL_RESP;
            resp_hit_q <= 1'b1;
          end else begin
            ctl_q      <= CTL_WAIT;
            wait_buf_q <= hit_idx;
          end
        end
        CTL_WAIT: if (wait_done) begin
          ctl_q      <= CTL_RESP;
          resp_hit_q <= 1'b1;
        end
        CTL_RESP: if (resp_ready) ctl_q <= CTL_IDLE;
        default: ctl_q <= CTL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       resp_data_q <= '0;
    else if (pop_v)   resp_data_q <= head_data[pop_buf];
    else if (alloc_v) resp_data_q <= '0;
  end

  // registered request: slot marked pending when loaded here
  always_ff @(posedge clk) begin
    if (!rst_n)       pf_valid_q <= 1'b0;
    else if (pf_load) pf_valid_q <= gnt_v;
  end

  always_ff @(posedge clk) begin
    if (pf_load && gnt_v) begin
      pf_line_q <= slot_line[gnt_buf][gnt_slot];
      pf_tag_q  <= {gen[gnt_buf], gnt_buf, gnt_slot};
    end
  end

  assign miss_ready = (ctl_q == CTL_IDLE);
  assign resp_valid = (ctl_q == CTL_RESP);
  assign resp_hit   = resp_hit_q;
  assign resp_data  = resp_data_q;
  assign pf_valid   = pf_valid_q;
  assign pf_line    = pf_line_q;
  assign pf_tag     = pf_tag_q;
endmodule

// File: rtl/strm_pf_chk.sv
module strm_pf_chk #(
  parameter int LINE_AW = 26,
  parameter int DATA_W  = 64,
  parameter int TAG_W   = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               miss_valid,
  input logic               miss_ready,
  input logic               resp_valid,
  input logic               resp_ready,
  input logic               resp_hit,
  input logic [DATA_W-1:0]  resp_data,
  input logic               pf_valid,
  input logic               pf_ready,
  input logic [LINE_AW-1:0] pf_line,
  input logic [TAG_W-1:0]   pf_tag
);
  // R9: stalled request holds
  assert_pf_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_line) && $stable(pf_tag));

  // R10: stalled response holds
  assert_resp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_hit) && $stable(resp_data));

  // R10: no new miss while a response is out
  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !miss_ready);

  // R10: one miss in flight
  assert_single_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && miss_ready |=> !miss_ready);

  // R10: response drops after its handshake
  assert_resp_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_ready |=> !resp_valid);
endmodule

bind strm_pf strm_pf_chk #(
  .LINE_AW(LINE_AW), .DATA_W(DATA_W), .TAG_W(TAG_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .miss_valid(miss_valid),
  .miss_ready(miss_ready),
  .resp_valid(resp_valid),
  .resp_ready(resp_ready),
  .resp_hit  (resp_hit),
  .resp_data (resp_data),
  .pf_valid  (pf_valid),
  .pf_ready  (pf_ready),
  .pf_line   (pf_line),
  .pf_tag    (pf_tag)
);

// File: tb/strm_pf_test.sv
module strm_pf_test;
  localparam int CLK_PERIOD = 10;
  localparam int LA = 20;
  localparam int DW = 32;
  localparam int TW = 3 + 2 + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_valid = 1'b0, miss_ready;
  logic [LA-1:0] miss_line = '0;
  logic resp_valid, resp_ready = 1'b1, resp_hit;
  logic [DW-1:0] resp_data;
  logic pf_valid, pf_ready = 1'b1;
  logic [LA-1:0] pf_line;
  logic [TW-1:0] pf_tag;
  logic fill_valid = 1'b0;
  logic [TW-1:0] fill_tag = '0;
  logic [DW-1:0] fill_data = '0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit mem_hold = 1'b0;
  int cnt_cross = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strm_pf #(.LINE_AW(LA), .DATA_W(DW), .NBUF(4), .DEPTH(2), .GEN_W(3), .PG_LOG2(4)) uut (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_line(miss_line),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_hit(resp_hit), .resp_data(resp_data),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_line(pf_line), .pf_tag(pf_tag),
    .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_data(fill_data)
  );

  function automatic logic [DW-1:0] pat(input logic [LA-1:0] l);
    return {l[15:0], ~l[15:0]};
  endfunction

  // memory model: requests captured at the handshake edge, one fill per cycle
  logic [LA-1:0] q_line [512];
  logic [TW-1:0] q_tag  [512];
  int q_wr = 0, q_rd = 0;

  always @(posedge clk) begin
    if (rst_n && pf_valid && pf_ready) begin
      q_line[q_wr] = pf_line;
      q_tag[q_wr]  = pf_tag;
      q_wr++;
      if (pf_line == 20'h00110) cnt_cross++;
    end
  end

  always @(negedge clk) begin
    fill_valid = 1'b0;
    if (!mem_hold && q_rd < q_wr) begin
      fill_valid = 1'b1;
      fill_tag   = q_tag[q_rd];
      fill_data  = pat(q_line[q_rd]);
      q_rd++;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_miss(input logic [LA-1:0] l);
    @(negedge clk);
    miss_valid = 1'b1;
    miss_line  = l;
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic get_resp(output logic ok, output logic h, output logic [DW-1:0] d);
    ok = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (resp_valid) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    h = resp_hit;
    d = resp_data;
  endtask

  // bit 20 = expected hit flag, bits 19:0 = miss line
  localparam logic [LA:0] VEC [16] = '{
    21'h0_00100, 21'h1_00101, 21'h1_00102, 21'h0_00200,
    21'h0_00202, 21'h1_00201, 21'h1_00103, 21'h0_00300,
    21'h0_00400, 21'h0_00203, 21'h0_00202, 21'h1_00301,
    21'h1_00204, 21'h0_0010E, 21'h1_0010F, 21'h0_00110
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc == 60000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic ok, h, stable;
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 miss_ready", miss_ready, 1);
    chk("R1 resp_valid", resp_valid, 0);
    chk("R1 pf_valid", pf_valid, 0);

    // R2 R3 R5 R6 R7 via vector walk
    for (int i = 0; i < 16; i++) begin
      send_miss(VEC[i][LA-1:0]);
      get_resp(ok, h, d);
      chk($sformatf("R2/R3 resp present step %0d", i), ok, 1);
      chk($sformatf("R3/R5/R6 hit flag step %0d line %0h", i, VEC[i][LA-1:0]), h, VEC[i][LA]);
      if (VEC[i][LA]) chk($sformatf("R3 hit data step %0d", i), d, pat(VEC[i][LA-1:0]));
      else            chk($sformatf("R2 miss data step %0d", i), d, 0);
      @(negedge clk);
      repeat (8) @(negedge clk);
    end
    chk("R7 no request across page edge", cnt_cross, 0);

    // R4: head pending
    mem_hold = 1'b1;
    send_miss(20'h00D00);
    get_resp(ok, h, d);
    chk("R2 miss D00", h, 0);
    @(negedge clk);
    repeat (8) @(negedge clk);
    send_miss(20'h00D01);
    stable = 1'b1;
    for (int i = 0; i < 5; i++) begin
      if (resp_valid) stable = 1'b0;
      @(negedge clk);
    end
    chk("R4 no response while fill pending", stable, 1);
    mem_hold = 1'b0;
    get_resp(ok, h, d);
    chk("R4 late hit flag", h, 1);
    chk("R4 late hit data", d, pat(20'h00D01));
    @(negedge clk);
    repeat (8) @(negedge clk);

    // R8: stale fill after restart
    mem_hold = 1'b1;
    send_miss(20'h00800); get_resp(ok, h, d); @(negedge clk); repeat (4) @(negedge clk);
    send_miss(20'h00900); get_resp(ok, h, d); @(negedge clk); repeat (4) @(negedge clk);
    send_miss(20'h00A00); get_resp(ok, h, d); @(negedge clk); repeat (4) @(negedge clk);
    send_miss(20'h00B00); get_resp(ok, h, d); @(negedge clk); repeat (4) @(negedge clk);
    send_miss(20'h00C00); get_resp(ok, h, d);
    chk("R6 C00 restarts LRU buffer", h, 0);
    @(negedge clk); repeat (4) @(negedge clk);
    mem_hold = 1'b0;
    repeat (30) @(negedge clk);
    send_miss(20'h00C01);
    get_resp(ok, h, d);
    chk("R8 hit after restart", h, 1);
    chk("R8 stale fill discarded", d, pat(20'h00C01));
    @(negedge clk);
    repeat (8) @(negedge clk);

    // R9: prefetch back-pressure
    pf_ready = 1'b0;
    send_miss(20'h00E00);
    get_resp(ok, h, d);
    chk("R2 miss E00", h, 0);
    @(negedge clk);
    stable = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (!pf_valid || pf_line != 20'h00E01) stable = 1'b0;
      @(negedge clk);
    end
    chk("R9 request held under back-pressure", stable, 1);
    pf_ready = 1'b1;
    repeat (10) @(negedge clk);

    // R10: response back-pressure
    resp_ready = 1'b0;
    send_miss(20'h00E01);
    get_resp(ok, h, d);
    stable = 1'b1;
    for (int i = 0; i < 3; i++) begin
      if (!resp_valid || !resp_hit || resp_data != pat(20'h00E01) || miss_ready) stable = 1'b0;
      @(negedge clk);
    end
    chk("R10 response held", stable, 1);
    resp_ready = 1'b1;
    @(negedge clk);
    chk("R10 response dropped after handshake", resp_valid, 0);
    chk("R10 idle again", miss_ready, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule